// File: doc/BRIEF.md
# Serial Flash Command Shift Engine

This block is a memory-mapped serial peripheral master that runs exactly one serial flash transaction for each start command. Software prepares the command in two 32-bit registers: a command word holding the instruction byte and an optional 24-bit flash address, and a data word holding up to four bytes to program. It then writes a control word that carries a transmit byte count, a receive byte count and a start bit. The engine lowers chip select, clocks the transmit bytes out on MOSI in SPI mode 0 and then clocks the receive bytes in from MISO. When it finishes it places the received bytes in the data word and clears its busy flag.

The register bus is single-cycle and has no back-pressure. A write is taken in the cycle where `bus_sel` and `bus_we` are both high. A read returns `bus_rdata` combinationally from `bus_addr` in the same cycle. While a transaction runs, all bus writes are dropped, so software polls the busy flag before it loads the next command. Transmit counts above 8 are treated as 8, and receive counts above 4 are treated as 4.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCLK is low, and the command word (address 0), data word (address 1) and control word (address 2) all read 0.
- R2: A control write with bit 8 (start) set and a nonzero transmit count in bits 3:0 makes bit 16 (busy) of the control word read 1 from the next cycle until the transaction ends. The control word reads back the transmit count in bits 3:0 and the receive count in bits 7:4.
- R3: Transmit bytes 1 to 4 are the command word's bytes, sent low byte first (bits 7:0, then 15:8, then 23:16, then 31:24). Each byte is shifted MSB first on MOSI, and MOSI is stable when SCLK rises.
- R4: When the transmit count is above 4, bytes 5 to 8 come from the data word in the order bits 7:0, 15:8, 23:16, 31:24.
- R5: Receive bytes are sampled on rising SCLK after all transmit bytes. The first received byte lands in data-word bits 7:0 and the next ones go to successively higher bytes. Bytes above the receive count read 0. The data word is updated in the same cycle that busy clears.
- R6: A transaction with a receive count of 0 leaves the data word unchanged.
- R7: SCLK has a period of CLK_DIV system clocks and rises 8×(tx+rx) times. Chip select stays low for exactly CLK_DIV×8×(tx+rx) + CLK_DIV/2 system clocks: half an SCLK period before the first rising edge and half a period after the last falling edge.
- R8: While busy, bus writes to any register are ignored. A second start does not begin a new transaction, and writes to the command or data word leave their contents unchanged.
- R9: A start with a transmit count of 0 produces no chip-select activity, and busy stays 0.
- R10: A transmit count above 8 sends 8 bytes, and a receive count above 4 receives 4 bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register bus select |
| bus_we | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 2 | Register index: 0 command, 1 data, 2 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (0 when not selected) |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The end of a receive transaction and a software write to the data word can land on the same clock edge: the engine loads the received bytes into the data word as busy clears, and a bus write to that register arrives in that same cycle. The bench provokes this by counting CLK_DIV×8×(tx+rx) + CLK_DIV/2 cycles from the start write and placing a data-word write on exactly that edge. The received bytes must win. A later data-word write issued once the engine is idle must then take effect, which shows that the gate does not block writes forever.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 2;
  localparam int CNT_W     = 4;
  localparam int TX_LSB    = 0;
  localparam int RX_LSB    = 4;
  localparam int START_BIT = 8;
  localparam int BUSY_BIT  = 16;
  localparam int MAX_TX    = 8;
  localparam int MAX_RX    = 4;

  localparam logic [ADDR_W-1:0] ADDR_CMD  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTL  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_TRAIL = 2'd2
  } shift_state_t;
endpackage

// File: rtl/spi_cmd_phase.sv
module spi_cmd_phase #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (HALF <= 1) begin : g_single
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(HALF);
      logic [CW-1:0] cnt_q;

      assign tick = run && (cnt_q == CW'(HALF - 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!run || tick) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
      end

      AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0)); // R7
    end
  endgenerate
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_word,
  output logic [WORD_W-1:0] cmd_q,
  output logic [WORD_W-1:0] data_q,
  output logic              start_req,
  output logic [CNT_W-1:0]  start_tx,
  output logic [CNT_W-1:0]  start_rx
);
  logic             wr_ok;
  logic [CNT_W-1:0] tx_f_q, rx_f_q;

  assign wr_ok     = bus_sel && bus_we && !busy;
  assign start_req = wr_ok && (bus_addr == ADDR_CTL) && bus_wdata[START_BIT];
  assign start_tx  = bus_wdata[TX_LSB +: CNT_W];
  assign start_rx  = bus_wdata[RX_LSB +: CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      tx_f_q <= '0;
      rx_f_q <= '0;
    end else begin
      if (wr_ok && bus_addr == ADDR_CMD) cmd_q <= bus_wdata;
      if (rx_valid)                          data_q <= rx_word;
      else if (wr_ok && bus_addr == ADDR_DATA) data_q <= bus_wdata;
      if (wr_ok && bus_addr == ADDR_CTL) begin
        tx_f_q <= bus_wdata[TX_LSB +: CNT_W];
        rx_f_q <= bus_wdata[RX_LSB +: CNT_W];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        ADDR_CMD:  bus_rdata = cmd_q;
        ADDR_DATA: bus_rdata = data_q;
        ADDR_CTL: begin
          bus_rdata[TX_LSB +: CNT_W] = tx_f_q;
          bus_rdata[RX_LSB +: CNT_W] = rx_f_q;
          bus_rdata[BUSY_BIT]        = busy;
        end
        default:   bus_rdata = '0;
      endcase
    end
  end

  AST_CMD_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_CMD && busy) |=> $stable(cmd_q)); // R8
  AST_DATA_KEEP_NORX: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rx_valid) |=> $stable(data_q)); // R6
  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_CTL && !busy && bus_wdata[START_BIT]
     && bus_wdata[TX_LSB +: CNT_W] != '0) |=> busy); // R2
  AST_TX0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_CTL && !busy && bus_wdata[START_BIT]
     && bus_wdata[TX_LSB +: CNT_W] == '0) |=> !busy); // R9
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [CNT_W-1:0]  start_tx,
  input  logic [CNT_W-1:0]  start_rx,
  input  logic [WORD_W-1:0] cmd_q,
  input  logic [WORD_W-1:0] data_q,
  input  logic              spi_miso,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  output logic              busy,
  output logic              done,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_word
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int BIT_W = $clog2((MAX_TX + MAX_RX) * 8) + 1;
  localparam int TXW   = $clog2(2 * WORD_W);
  localparam int RXW   = $clog2(WORD_W);

  shift_state_t      state_q;
  logic              tick;
  logic              cs_n_q, sclk_q, mosi_q, busy_q, rx_any_q;
  logic [BIT_W-1:0]  bit_q, ntx_q, nall_q;
  logic [WORD_W-1:0] rx_acc_q;
  logic [2*WORD_W-1:0] tx_word;
  logic [CNT_W-1:0]  tx_c, rx_c;
  logic [BIT_W-1:0]  ntx_l, nall_l;
  logic [RXW-1:0]    rx_pos;

  spi_cmd_phase #(.HALF(HALF)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q != ST_IDLE),
    .tick  (tick)
  );

  assign tx_word = {data_q, cmd_q};
  assign tx_c    = (start_tx > CNT_W'(MAX_TX)) ? CNT_W'(MAX_TX) : start_tx;
  assign rx_c    = (start_rx > CNT_W'(MAX_RX)) ? CNT_W'(MAX_RX) : start_rx;
  assign ntx_l   = BIT_W'(tx_c) << 3;
  assign nall_l  = (BIT_W'(tx_c) + BIT_W'(rx_c)) << 3;
  assign rx_pos  = RXW'(bit_q - ntx_q) ^ RXW'(7);

  function automatic logic tx_bit(input logic [BIT_W-1:0] k,
                                  input logic [BIT_W-1:0] ntx,
                                  input logic [2*WORD_W-1:0] w);
    if (k < ntx) return w[TXW'(k) ^ TXW'(7)];
    return 1'b0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cs_n_q   <= 1'b1;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
      busy_q   <= 1'b0;
      rx_any_q <= 1'b0;
      bit_q    <= '0;
      ntx_q    <= '0;
      nall_q   <= '0;
      rx_acc_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_req && tx_c != '0) begin
            state_q  <= ST_XFER;
            cs_n_q   <= 1'b0;
            busy_q   <= 1'b1;
            bit_q    <= '0;
            ntx_q    <= ntx_l;
            nall_q   <= nall_l;
            rx_acc_q <= '0;
            rx_any_q <= (rx_c != '0);
            mosi_q   <= tx_bit('0, ntx_l, tx_word);
          end
        end
        ST_XFER: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              if (bit_q >= ntx_q) rx_acc_q[rx_pos] <= spi_miso;
            end else begin
              sclk_q <= 1'b0;
              if (bit_q == nall_q - 1'b1) begin
                state_q <= ST_TRAIL;
                mosi_q  <= 1'b0;
              end else begin
                bit_q  <= bit_q + 1'b1;
                mosi_q <= tx_bit(bit_q + 1'b1, ntx_q, tx_word);
              end
            end
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            state_q <= ST_IDLE;
            cs_n_q  <= 1'b1;
            busy_q  <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done     = (state_q == ST_TRAIL) && tick;
  assign rx_valid = done && rx_any_q;
  assign rx_word  = rx_acc_q;
  assign spi_cs_n = cs_n_q;
  assign spi_sclk = sclk_q;
  assign spi_mosi = mosi_q;
  assign busy     = busy_q;

  AST_CS_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> cs_n_q); // R1
  AST_SCLK_LOW_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !sclk_q); // R7
  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi_q)); // R3
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic              busy, done, rx_valid, start_req;
  logic [WORD_W-1:0] rx_word, cmd_q, data_q;
  logic [CNT_W-1:0]  start_tx, start_rx;

  spi_cmd_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .done      (done),
    .rx_valid  (rx_valid),
    .rx_word   (rx_word),
    .cmd_q     (cmd_q),
    .data_q    (data_q),
    .start_req (start_req),
    .start_tx  (start_tx),
    .start_rx  (start_rx)
  );

  spi_cmd_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .start_tx  (start_tx),
    .start_rx  (start_rx),
    .cmd_q     (cmd_q),
    .data_q    (data_q),
    .spi_miso  (spi_miso),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .busy      (busy),
    .done      (done),
    .rx_valid  (rx_valid),
    .rx_word   (rx_word)
  );
endmodule

// File: tb/spi_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb_top;
  localparam int DIV = 4;
  localparam logic [1:0] A_CMD = 2'd0, A_DAT = 2'd1, A_CTL = 2'd2;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic spi_cs_n, spi_sclk, spi_mosi;
  logic spi_miso = 0;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] resp [4];
  int sl_tx = 0, bitk = 0, rises = 0, cs_falls = 0, cs_low = 0;
  logic cap [0:127];

  always #10 clk = ~clk;

  spi_cmd_engine #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso));

  function automatic logic resp_bit(int k);
    int r;
    if (k < sl_tx * 8) return 1'b0;
    r = k - sl_tx * 8;
    if (r / 8 > 3) return 1'b0;
    return resp[r / 8][7 - r % 8];
  endfunction

  always @(negedge spi_cs_n) begin
    cs_falls++;
    bitk = 0;
    spi_miso = resp_bit(0);
  end
  always @(posedge spi_sclk) begin
    if (bitk < 128) cap[bitk] = spi_mosi;
    rises++;
    bitk++;
  end
  always @(negedge spi_sclk) spi_miso = resp_bit(bitk);
  always @(posedge clk) if (spi_cs_n === 1'b0) cs_low++;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      bus_read(A_CTL, v);
      if (!v[16]) return;
    end
    chk("R2", "busy never cleared", 32'd1, 32'd0);
  endtask

  task automatic clr_mon(int tx);
    rises = 0; cs_falls = 0; cs_low = 0; sl_tx = tx;
  endtask

  task automatic chk_tx(string req, logic [31:0] c, logic [31:0] d, int nbytes);
    int mism = 0;
    for (int k = 0; k < nbytes * 8; k++) begin
      logic [7:0] b;
      b = (k / 8 < 4) ? c[8*(k/8) +: 8] : d[8*(k/8-4) +: 8];
      if (cap[k] !== b[7 - k % 8]) mism++;
    end
    chk(req, "mosi bit mismatches", mism, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1", "cs_n", {31'd0, spi_cs_n}, 1);
    chk("R1", "sclk", {31'd0, spi_sclk}, 0);
    bus_read(A_CMD, v); chk("R1", "cmd", v, 0);
    bus_read(A_DAT, v); chk("R1", "data", v, 0);
    bus_read(A_CTL, v); chk("R1", "ctl", v, 0);
  endtask

  task automatic t_wren();
    logic [31:0] v;
    bus_write(A_CMD, 32'h0000_0006);
    bus_write(A_DAT, 32'hCAFE_F00D);
    clr_mon(1);
    bus_write(A_CTL, 32'h0000_0101);
    bus_read(A_CTL, v); chk("R2", "ctl while busy", v, 32'h0001_0001);
    wait_idle();
    bus_read(A_CTL, v); chk("R2", "ctl after", v, 32'h0000_0001);
    chk_tx("R3", 32'h6, 0, 1);
    chk("R7", "rises tx1", rises, 8);
    chk("R7", "cs low cycles tx1", cs_low, DIV * 8 + DIV / 2);
    bus_read(A_DAT, v); chk("R6", "data untouched", v, 32'hCAFE_F00D);
  endtask

  task automatic t_status();
    logic [31:0] v;
    resp[0] = 8'hA5; resp[1] = 8'h5A; resp[2] = 8'h77; resp[3] = 8'h88;
    bus_write(A_CMD, 32'h0000_0005);
    clr_mon(1);
    bus_write(A_CTL, 32'h0000_0111);
    wait_idle();
    bus_read(A_DAT, v); chk("R5", "status byte", v, 32'h0000_00A5);
    chk("R7", "rises tx1 rx1", rises, 16);
    chk("R7", "cs low tx1 rx1", cs_low, DIV * 16 + DIV / 2);
  endtask

  task automatic t_read4();
    logic [31:0] v;
    resp[0] = 8'h11; resp[1] = 8'h22; resp[2] = 8'h33; resp[3] = 8'h44;
    bus_write(A_CMD, 32'h1234_5603);
    clr_mon(4);
    bus_write(A_CTL, 32'h0000_0144);
    wait_idle();
    chk_tx("R3", 32'h1234_5603, 0, 4);
    bus_read(A_DAT, v); chk("R5", "read 4 bytes", v, 32'h4433_2211);
    chk("R7", "rises tx4 rx4", rises, 64);
  endtask

  task automatic t_program();
    logic [31:0] v;
    bus_write(A_CMD, 32'hABCD_EF02);
    bus_write(A_DAT, 32'h89AB_CDEF);
    clr_mon(7);
    bus_write(A_CTL, 32'h0000_0107);
    wait_idle();
    chk_tx("R4", 32'hABCD_EF02, 32'h89AB_CDEF, 7);
    chk("R4", "rises tx7", rises, 56);
    bus_read(A_DAT, v); chk("R6", "data after program", v, 32'h89AB_CDEF);
  endtask

  task automatic t_tx0();
    logic [31:0] v;
    clr_mon(0);
    bus_write(A_CTL, 32'h0000_0130);
    bus_read(A_CTL, v); chk("R9", "busy after tx0", {31'd0, v[16]}, 0);
    repeat (20) @(negedge clk);
    chk("R9", "cs falls", cs_falls, 0);
    chk("R9", "cs low cycles", cs_low, 0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    resp[0] = 8'h3C;
    bus_write(A_CMD, 32'h0000_009F);
    clr_mon(1);
    bus_write(A_CTL, 32'h0000_0111);
    bus_write(A_CTL, 32'h0000_0148);
    bus_write(A_CMD, 32'hDEAD_BEEF);
    bus_write(A_DAT, 32'h1111_1111);
    wait_idle();
    repeat (40) @(negedge clk);
    chk("R8", "cs falls", cs_falls, 1);
    chk("R8", "rises", rises, 16);
    bus_read(A_CMD, v); chk("R8", "cmd kept", v, 32'h0000_009F);
    bus_read(A_CTL, v); chk("R8", "ctl kept", v, 32'h0000_0011);
    bus_read(A_DAT, v); chk("R8", "data is rx", v, 32'h0000_003C);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    resp[0] = 8'h9A; resp[1] = 8'hBC;
    bus_write(A_CMD, 32'h0000_0003);
    clr_mon(1);
    bus_write(A_CTL, 32'h0000_0121);
    repeat (DIV * 24 + DIV / 2 - 2) @(negedge clk);
    bus_write(A_DAT, 32'h5555_5555);
    wait_idle();
    bus_read(A_DAT, v); chk("R5", "rx wins same-cycle write", v, 32'h0000_BC9A);
    bus_write(A_DAT, 32'h6666_6666);
    bus_read(A_DAT, v); chk("R8", "idle write lands", v, 32'h6666_6666);
  endtask

  task automatic t_clamp();
    logic [31:0] v;
    bus_write(A_CMD, 32'h0403_0201);
    bus_write(A_DAT, 32'h0807_0605);
    clr_mon(8);
    bus_write(A_CTL, 32'h0000_010F);
    wait_idle();
    chk("R10", "rises tx15", rises, 64);
    chk_tx("R10", 32'h0403_0201, 32'h0807_0605, 8);
    resp[0] = 8'hD1; resp[1] = 8'hD2; resp[2] = 8'hD3; resp[3] = 8'hD4;
    clr_mon(1);
    bus_write(A_CTL, 32'h0000_0171);
    wait_idle();
    chk("R10", "rises rx7", rises, 40);
    bus_read(A_DAT, v); chk("R10", "rx clamp data", v, 32'hD4D3_D2D1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_wren();
    t_status();
    t_read4();
    t_program();
    t_tx0();
    t_busy_ignore();
    t_collide();
    t_clamp();
    summary();
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule